// File: doc/BRIEF.md
# Bus Slot Sequencer for Shared Video Memory

This block sets the timing of a memory shared by a CPU and a video fetcher. From a fast master clock it derives a CPU clock at one quarter of the master rate, and a two-bit bus slot number that rotates through four values, moving on once every four master cycles. The video fetcher may read memory only in the even slots. The block flags any video read it sees in an odd slot and swaps the bytes of each 16-bit lane of the fetched word.

CPU writes to the video register file pass through the block. A requester offers an address and a 16-bit word with a valid/ready handshake. The block holds one write at a time and presents it to the register file only at a fixed point of slot 0, as a full-word write lasting one slot. The register select is raised only when the address falls inside the video register page. The word index is taken from the low address byte.

Top module: `bus_slot_seq`

## Requirements
- R1: A two-bit phase counter is 0 during reset and increments on every master clock edge after reset. `cpu_clk` is high exactly when the phase is 2 or 3, so it is low for two master cycles and then high for two.
- R2: `bus_slot` is 0 during reset. It increments by one, modulo 4, only on the edge that leaves phase 1. It holds its value on every other edge.
- R3: `vid_ok` is high exactly while `bus_slot` is 0 or 2.
- R4: `rd_err` is high exactly when `vid_rd` is high while `bus_slot` is 1 or 3.
- R5: A held write starts its register window only on the edge that enters phase 2 of slot 0. The window lasts four master cycles and closes on the edge that enters phase 2 of slot 1.
- R6: During a window, `reg_rw_n`, `reg_uds_n` and `reg_lds_n` are all low, which marks a full 16-bit write. Outside a window all three are high.
- R7: `reg_sel` is high during a window only if the write address, with its low 8 bits cleared, equals 0xFF8200. Otherwise the window runs with `reg_sel` low. `reg_sel` is never high outside a window.
- R8: During a window, `reg_idx` equals bits 7..1 of the write address (the low address byte shifted right by one), and `reg_data` equals the written word.
- R9: `wr_ready` is low while a write is held and unissued. A request kept valid during that time is accepted only after the held write has issued. Writes issue in acceptance order, at most one per four-slot rotation.
- R10: For each 16-bit lane i of `mem_rdata`, `vid_data` carries the lane with its two bytes exchanged: bits 16i+7..16i come from bits 16i+15..16i+8, and the other way round.
- R11: During reset, `cpu_clk` is 0, `bus_slot` is 0, `wr_ready` is 1, `reg_sel` is 0, and the three write strobes are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | CPU write request offered |
| wr_addr | input | 24 | Byte address of the CPU write |
| wr_data | input | 16 | Word to write |
| wr_ready | output | 1 | Write can be accepted on this edge |
| vid_rd | input | 1 | Video fetcher is reading memory |
| mem_rdata | input | 64 | Word fetched from memory |
| vid_data | output | 64 | Fetched word with bytes swapped per lane |
| cpu_clk | output | 1 | Derived CPU clock, master divided by 4 |
| bus_slot | output | 2 | Current bus slot number |
| vid_ok | output | 1 | Video read permitted in this slot |
| rd_err | output | 1 | Video read attempted in a forbidden slot |
| reg_sel | output | 1 | Register file select, address in register page |
| reg_idx | output | 7 | Register word index |
| reg_data | output | 16 | Register write data |
| reg_rw_n | output | 1 | Read/write line, low for write |
| reg_uds_n | output | 1 | Upper byte strobe, active low |
| reg_lds_n | output | 1 | Lower byte strobe, active low |

## Verification
A phase counter that slips or misses a count shows within one four-cycle window as a wrong `cpu_clk` level. It also shows in the next slot change, and from then on the slot sequence drifts against a count of edges since reset. A wrong slot value appears at once on `vid_ok` and `rd_err`, and in the next write window, which then opens outside phase 2 of slot 0. Pending-write state that is lost or overwritten shows when the window opens, at most sixteen cycles later: the window then carries a word or index that differs from the oldest accepted request, or the expected window never comes.

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int ADDR_W  = 24;
  localparam int DATA_W  = 16;
  localparam int PH_W    = 2;
  localparam int SLOT_W  = 2;
  localparam int IDX_W   = 7;
  localparam int BYTE_W  = 8;

  localparam logic [PH_W-1:0] PH_ADV   = PH_W'(1);
  localparam logic [PH_W-1:0] PH_ISSUE = PH_W'(2);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;

  // address with its low byte cleared compared to the page base
  function automatic logic page_hit(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] page);
    return {a[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}} == page;
  endfunction

  // low address byte divided by two
  function automatic logic [IDX_W-1:0] word_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W:1];
  endfunction

  function automatic logic [DATA_W-1:0] swap16(input logic [DATA_W-1:0] w);
    return {w[BYTE_W-1:0], w[DATA_W-1:BYTE_W]};
  endfunction
endpackage

// File: rtl/bss_timebase.sv
module bss_timebase
  import bss_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [PH_W-1:0]   phase,
  output logic [SLOT_W-1:0] slot,
  output logic              cpu_clk,
  output logic              adv_evt,
  output logic              issue_evt,
  output logic              close_evt,
  output logic              vid_ok
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = {SLOT_W{1'b1}};

  logic [PH_W-1:0]   phase_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      slot_q  <= '0;
    end else begin
      phase_q <= phase_q + PH_W'(1);
      if (phase_q == PH_ADV) slot_q <= slot_q + SLOT_W'(1);
    end
  end

  assign phase     = phase_q;
  assign slot      = slot_q;
  assign cpu_clk   = phase_q[PH_W-1];
  assign adv_evt   = (phase_q == PH_ADV);
  assign issue_evt = adv_evt && (slot_q == LAST_SLOT);
  assign close_evt = adv_evt && (slot_q == '0);
  assign vid_ok    = ~slot_q[0];

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase_q == $past(phase_q) + PH_W'(1));
  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ADV) |=> slot_q == $past(slot_q) + SLOT_W'(1));
  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_ADV) |=> $stable(slot_q));
endmodule

// File: rtl/bss_wr_issue.sv
module bss_wr_issue
  import bss_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_PAGE = 24'hFF8200
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic [PH_W-1:0]   phase,
  input  logic [SLOT_W-1:0] slot,
  input  logic              issue_evt,
  input  logic              close_evt,
  output logic              reg_sel,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_data,
  output logic              reg_rw_n,
  output logic              reg_uds_n,
  output logic              reg_lds_n
);
  logic              pend_q;
  wr_req_t           pend_req;
  logic              act_q;
  logic              hit_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] dat_q;

  logic accept;
  logic issue_now;

  assign wr_ready  = ~pend_q;
  assign accept    = wr_valid && ~pend_q;
  assign issue_now = issue_evt && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      pend_req <= '0;
    end else if (accept) begin
      pend_q        <= 1'b1;
      pend_req.addr <= wr_addr;
      pend_req.data <= wr_data;
    end else if (issue_now) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      hit_q <= 1'b0;
      idx_q <= '0;
      dat_q <= '0;
    end else if (issue_now) begin
      act_q <= 1'b1;
      hit_q <= page_hit(pend_req.addr, REG_PAGE);
      idx_q <= word_idx(pend_req.addr);
      dat_q <= pend_req.data;
    end else if (close_evt) begin
      act_q <= 1'b0;
      hit_q <= 1'b0;
    end
  end

  assign reg_sel   = act_q && hit_q;
  assign reg_idx   = idx_q;
  assign reg_data  = dat_q;
  assign reg_rw_n  = ~act_q;
  assign reg_uds_n = ~act_q;
  assign reg_lds_n = ~act_q;

  // R5
  win_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q) |-> (slot == '0) && (phase == PH_ISSUE));
  // R5
  win_close_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q) |-> (slot == SLOT_W'(1)) && (phase == PH_ISSUE));
  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !issue_evt) |=> pend_q && $stable(pend_req));
endmodule

// File: rtl/bss_lane_swap.sv
module bss_lane_swap
  import bss_pkg::*;
#(
  parameter int LANES = 4
)(
  input  logic [LANES*DATA_W-1:0] din,
  output logic [LANES*DATA_W-1:0] dout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dout[i*DATA_W +: DATA_W] = swap16(din[i*DATA_W +: DATA_W]);
  end
endmodule

// File: rtl/bus_slot_seq.sv
module bus_slot_seq
  import bss_pkg::*;
#(
  parameter int                LANES    = 4,
  parameter logic [ADDR_W-1:0] REG_PAGE = 24'hFF8200,
  localparam int               MEM_W    = LANES * DATA_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              vid_rd,
  input  logic [MEM_W-1:0]  mem_rdata,
  output logic [MEM_W-1:0]  vid_data,
  output logic              cpu_clk,
  output logic [SLOT_W-1:0] bus_slot,
  output logic              vid_ok,
  output logic              rd_err,
  output logic              reg_sel,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_data,
  output logic              reg_rw_n,
  output logic              reg_uds_n,
  output logic              reg_lds_n
);
  logic [PH_W-1:0] phase;
  logic adv_evt, issue_evt, close_evt;

  bss_timebase u_tb (
    .clk(clk), .rst(rst), .phase(phase), .slot(bus_slot),
    .cpu_clk(cpu_clk), .adv_evt(adv_evt), .issue_evt(issue_evt),
    .close_evt(close_evt), .vid_ok(vid_ok)
  );

  bss_wr_issue #(.REG_PAGE(REG_PAGE)) u_wr (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .phase(phase), .slot(bus_slot),
    .issue_evt(issue_evt), .close_evt(close_evt), .reg_sel(reg_sel),
    .reg_idx(reg_idx), .reg_data(reg_data), .reg_rw_n(reg_rw_n),
    .reg_uds_n(reg_uds_n), .reg_lds_n(reg_lds_n)
  );

  bss_lane_swap #(.LANES(LANES)) u_swap (
    .din(mem_rdata), .dout(vid_data)
  );

  assign rd_err = vid_rd && ~vid_ok;

  // R4
  rd_err_slot_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> bus_slot[0]);
  // R7
  sel_window_chk: assert property (@(posedge clk) disable iff (rst)
    reg_sel |-> !reg_rw_n && (bus_slot <= SLOT_W'(1)));
endmodule

// File: tb/bus_slot_seq_test.sv
module bus_slot_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_ready;
  logic        vid_rd = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [63:0] vid_data;
  logic        cpu_clk;
  logic [1:0]  bus_slot;
  logic        vid_ok, rd_err, reg_sel;
  logic [6:0]  reg_idx;
  logic [15:0] reg_data;
  logic        reg_rw_n, reg_uds_n, reg_lds_n;

  int checks = 0;
  int errors = 0;
  int k = 0;
  bit done = 0;

  typedef struct {bit hit; logic [6:0] idx; logic [15:0] data;} exp_t;
  exp_t sb[$];

  bus_slot_seq uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .vid_rd(vid_rd),
    .mem_rdata(mem_rdata), .vid_data(vid_data), .cpu_clk(cpu_clk),
    .bus_slot(bus_slot), .vid_ok(vid_ok), .rd_err(rd_err), .reg_sel(reg_sel),
    .reg_idx(reg_idx), .reg_data(reg_data), .reg_rw_n(reg_rw_n),
    .reg_uds_n(reg_uds_n), .reg_lds_n(reg_lds_n)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) k <= 0;
    else k <= k + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [23:0] a, input logic [15:0] d);
    exp_t e;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    e.hit  = (a[23:8] == 16'hFF82);
    e.idx  = a[7:1];
    e.data = d;
    sb.push_back(e);
    // R9: just accepted, still held
    chk(wr_ready == 1'b0, "R9", "ready after accept", wr_ready, 0);
  endtask

  // input pattern driver for the video side
  initial begin
    forever begin
      @(negedge clk);
      vid_rd    = (k % 3) != 0;
      mem_rdata = {16'(k * 3), 16'hA55A, 16'(k ^ 16'h1234), 16'(k * 16'h0101 + 7)};
    end
  end

  // monitor
  int  win_len = 0;
  bit  last_rwn = 1'b1;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst) begin
        // R11
        chk(cpu_clk == 0 && bus_slot == 0 && wr_ready == 1 && reg_sel == 0 &&
            reg_rw_n && reg_uds_n && reg_lds_n, "R11", "reset state",
            {cpu_clk, bus_slot, wr_ready, reg_sel, reg_rw_n}, 5'b00101);
      end else begin
        automatic int ph = k % 4;
        automatic int es = ((k + 2) / 4) % 4;
        automatic logic [63:0] ev;
        // R1
        chk(cpu_clk == (ph >= 2), "R1", "cpu_clk", cpu_clk, ph >= 2);
        // R2
        chk(bus_slot == es, "R2", "bus_slot", bus_slot, es);
        // R3
        chk(vid_ok == (es % 2 == 0), "R3", "vid_ok", vid_ok, es % 2 == 0);
        // R4
        chk(rd_err == (vid_rd && es % 2 == 1), "R4", "rd_err", rd_err,
            vid_rd && es % 2 == 1);
        // R10
        for (int b = 0; b < 8; b++) ev[b*8 +: 8] = mem_rdata[(b ^ 1)*8 +: 8];
        chk(vid_data == ev, "R10", "vid_data", vid_data, ev);
        // R6
        chk(reg_uds_n == reg_rw_n && reg_lds_n == reg_rw_n, "R6", "strobes",
            {reg_uds_n, reg_lds_n}, {reg_rw_n, reg_rw_n});
        // R7
        if (reg_rw_n) chk(reg_sel == 0, "R7", "sel outside window", reg_sel, 0);
        if (last_rwn && !reg_rw_n) begin
          // R5
          chk(ph == 2 && es == 0, "R5", "window open point", ph * 4 + es, 8);
          if (sb.size() == 0) begin
            chk(0, "R9", "window with nothing accepted", 1, 0);
          end else begin
            automatic exp_t e = sb.pop_front();
            // R7
            chk(reg_sel == e.hit, "R7", "reg_sel", reg_sel, e.hit);
            // R8
            chk(reg_idx == e.idx, "R8", "reg_idx", reg_idx, e.idx);
            chk(reg_data == e.data, "R8", "reg_data", reg_data, e.data);
          end
          win_len = 0;
        end
        if (!reg_rw_n) win_len++;
        if (!last_rwn && reg_rw_n)
          // R5
          chk(win_len == 4 && ph == 2 && es == 1, "R5", "window length", win_len, 4);
        last_rwn = reg_rw_n;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    do_write(24'hFF8240, 16'h1234);
    do_write(24'hFF8260, 16'hBEEF);
    do_write(24'hFF8301, 16'h0F0F);
    do_write(24'hFF82FE, 16'h8001);
    do_write(24'h008200, 16'h5555);
    repeat (7) @(negedge clk);
    do_write(24'hFF8203, 16'hCAFE);
    repeat (40) @(negedge clk);
    // R9: every accepted write has issued
    chk(sb.size() == 0, "R9", "unissued writes", sb.size(), 0);
    chk(wr_ready == 1, "R9", "ready when idle", wr_ready, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        chk(0, "R9", "watchdog expired", 1, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule